// File: doc/BRIEF.md
# I2C Master Host Register Bank

This block is the host-side register bank of an I2C master. A host reaches it through a small synchronous slave port. The port has an 8-bit data path and a 3-bit address, and every access is acknowledged exactly one cycle after it is strobed. The bank holds the following state:

- a 16-bit divider value for the serial clock;
- a control byte with a core-enable bit and an interrupt-enable bit;
- the byte to send and the last byte received;
- a self-clearing command byte;
- a status byte.

The command bits, the byte to send and the divider value go straight to a byte-level sequencer through registered outputs. The bank collects the sequencer's completion pulse, received acknowledge, bus-busy level, arbitration-loss pulse and received byte. It raises a registered interrupt when a transfer ends and interrupts are enabled.

Two addresses are shared by direction. A write to address 3 loads the byte to send, and a read of address 3 returns the received byte. A write to address 4 issues a command, and a read of address 4 returns the status. The divider value is the system clock divided by five times the wanted serial clock rate, minus one. For example, 32 MHz and 100 kHz give 63. Software programs it while the core is disabled.

Top module: `i2cm_hostregs`

## Requirements
- R1: Address 0 holds divider bits 7:0 and address 1 holds bits 15:8, both readable and writable and driven on the divider output. Address 2 is the control byte: bit 7 is core enable and bit 6 is interrupt enable. The other control bits read as zero.
- R2: After reset the divider reads 0xFFFF. Control, receive and status read 0x00, all command outputs are low, and the interrupt output is low.
- R3: A write to address 3 loads the byte-to-send output, and a read of address 3 returns the received byte. A write to address 4 loads the command byte, and a read of address 4 returns the status byte, never the command bits.
- R4: An access strobed with no acknowledge pending gets the acknowledge one cycle later. The acknowledge lasts one cycle, and read data is valid with it.
- R5: A command write takes effect only while core enable is set; otherwise the command outputs and the interrupt flag keep their values. A command already pending keeps its outputs after enable is cleared, until the sequencer completes it.
- R6: Command layout: bit 7 start, bit 6 stop, bit 5 read, bit 4 write, bit 3 acknowledge value to send, bit 0 interrupt acknowledge. The start, stop, read, write and acknowledge-value outputs clear on a completion pulse or an arbitration-loss pulse. The interrupt-acknowledge bit lasts one cycle.
- R7: Status layout: bit 7 received acknowledge, bit 6 bus busy, bit 5 arbitration lost, bit 1 transfer in progress, bit 0 interrupt flag. All other bits read as zero. Transfer in progress is high while a read or write command is pending and low once it completes.
- R8: A completion or arbitration-loss pulse sets the interrupt flag. An accepted interrupt-acknowledge command clears it. The interrupt output follows the flag ANDed with interrupt enable.
- R9: The arbitration-lost status bit stays set until a command with the start bit set is accepted.
- R10: The received byte is captured on the completion pulse. The received-acknowledge and bus-busy status bits follow the sequencer's inputs.
- R11: An asynchronous reset, whose active level is a parameter (active low by default), and a synchronous reset input each return every register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arstIn | input | 1 | Asynchronous reset, active level set by parameter |
| srstIn | input | 1 | Synchronous reset, active high |
| busCyc | input | 1 | Host cycle valid |
| busStb | input | 1 | Host strobe |
| busWe | input | 1 | Host write (1) or read (0) |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Registered read data |
| busAck | output | 1 | Access acknowledge, one cycle |
| irqOut | output | 1 | Interrupt request |
| prescale | output | 16 | Serial clock divider value |
| coreEn | output | 1 | Core enable |
| txByte | output | 8 | Byte to send |
| cmdStart | output | 1 | Start condition requested |
| cmdStop | output | 1 | Stop condition requested |
| cmdRead | output | 1 | Byte read requested |
| cmdWrite | output | 1 | Byte write requested |
| cmdAckBit | output | 1 | Acknowledge value to send after a read |
| ctlDone | input | 1 | Sequencer completion pulse |
| ctlAckIn | input | 1 | Acknowledge received from the slave |
| ctlBusy | input | 1 | Bus busy level |
| ctlArbLost | input | 1 | Arbitration-loss pulse |
| ctlRxByte | input | 8 | Byte received by the sequencer |

## Verification
A wrong command register shows at the command outputs on the cycle after the write, or after the completion pulse. It also shows in the transfer-in-progress status bit on the next status read. A stuck or missed interrupt flag shows at the interrupt output two cycles after the completion or arbitration-loss pulse, and in status bit 0 on the next read. Decode or direction mistakes on the shared addresses return the wrong byte in the same read access. They also move the byte-to-send output at the wrong time.

// File: rtl/i2cm_hostregs_pkg.sv
package i2cm_hostregs_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int PRE_BYTES = 2;
  localparam int PRE_W     = PRE_BYTES * DATA_W;

  // address decode: divider bytes occupy 0..PRE_BYTES-1
  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(PRE_BYTES);
  localparam logic [ADDR_W-1:0] ADR_DATA = ADDR_W'(PRE_BYTES + 1);
  localparam logic [ADDR_W-1:0] ADR_CMD  = ADDR_W'(PRE_BYTES + 2);

  // control bit positions
  localparam int CTL_EN  = 7;
  localparam int CTL_IEN = 6;

  // command bit positions
  localparam int CMD_STA  = 7;
  localparam int CMD_STO  = 6;
  localparam int CMD_RD   = 5;
  localparam int CMD_WR   = 4;
  localparam int CMD_ACK  = 3;
  localparam int CMD_IACK = 0;

  // strobes from access control to datapath
  typedef struct packed {
    logic [PRE_BYTES-1:0] wrPre;
    logic                 wrCtrl;
    logic                 wrData;
    logic                 wrCmd;
    logic                 rdLatch;
    logic [ADDR_W-1:0]    addr;
  } regStrobe_t;

endpackage

// File: rtl/i2cm_hostregs_ctl.sv
module i2cm_hostregs_ctl
  import i2cm_hostregs_pkg::*;
(
  input  logic              clk,
  input  logic              arstN,
  input  logic              srstIn,
  input  logic              busCyc,
  input  logic              busStb,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busAck,
  output regStrobe_t        strb
);

  logic accStart;
  assign accStart = busCyc && busStb && !busAck;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)      busAck <= 1'b0;
    else if (srstIn) busAck <= 1'b0;
    else             busAck <= accStart;
  end

  genvar gi;
  generate
    for (gi = 0; gi < PRE_BYTES; gi++) begin : g_preDec
      assign strb.wrPre[gi] = accStart && busWe && (busAddr == ADDR_W'(gi));
    end
  endgenerate

  assign strb.wrCtrl  = accStart && busWe && (busAddr == ADR_CTRL);
  assign strb.wrData  = accStart && busWe && (busAddr == ADR_DATA);
  assign strb.wrCmd   = accStart && busWe && (busAddr == ADR_CMD);
  assign strb.rdLatch = accStart && !busWe;
  assign strb.addr    = busAddr;

  // R4: acknowledge follows a fresh strobe by one cycle
  assert_ack_follows_R4: assert property (@(posedge clk) disable iff (!arstN || srstIn)
    (busCyc && busStb && !busAck) |=> busAck);

  // R4: acknowledge never lasts two cycles
  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!arstN || srstIn)
    busAck |=> !busAck);

endmodule

// File: rtl/i2cm_hostregs_dp.sv
module i2cm_hostregs_dp
  import i2cm_hostregs_pkg::*;
(
  input  logic              clk,
  input  logic              arstN,
  input  logic              srstIn,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut,
  output logic [PRE_W-1:0]  prescale,
  output logic              coreEn,
  output logic [DATA_W-1:0] txByte,
  output logic              cmdStart,
  output logic              cmdStop,
  output logic              cmdRead,
  output logic              cmdWrite,
  output logic              cmdAckBit,
  input  logic              ctlDone,
  input  logic              ctlAckIn,
  input  logic              ctlBusy,
  input  logic              ctlArbLost,
  input  logic [DATA_W-1:0] ctlRxByte
);

  logic [PRE_W-1:0]  preReg;
  logic              ctrlEn, ctrlIen;
  logic [DATA_W-1:0] txReg, rxReg;
  logic              cStart, cStop, cRead, cWrite, cAck, cIack;
  logic              stRxAck, stBusy, stArb, irqFlag;
  logic              tip;
  logic [DATA_W-1:0] statusByte, ctrlByte, rdMux;
  logic              cmdAccept, cmdEnd;

  assign tip       = cRead || cWrite;
  assign cmdAccept = strb.wrCmd && ctrlEn;
  assign cmdEnd    = ctlDone || ctlArbLost;

  // divider bytes
  genvar gi;
  generate
    for (gi = 0; gi < PRE_BYTES; gi++) begin : g_preReg
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN)                preReg[gi*DATA_W +: DATA_W] <= '1;
        else if (srstIn)           preReg[gi*DATA_W +: DATA_W] <= '1;
        else if (strb.wrPre[gi])   preReg[gi*DATA_W +: DATA_W] <= busWrData;
      end
    end
  endgenerate

  // control and byte to send
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      ctrlEn <= 1'b0; ctrlIen <= 1'b0; txReg <= '0;
    end else if (srstIn) begin
      ctrlEn <= 1'b0; ctrlIen <= 1'b0; txReg <= '0;
    end else begin
      if (strb.wrCtrl) begin
        ctrlEn  <= busWrData[CTL_EN];
        ctrlIen <= busWrData[CTL_IEN];
      end
      if (strb.wrData) txReg <= busWrData;
    end
  end

  // command byte: self clearing
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      {cStart, cStop, cRead, cWrite, cAck, cIack} <= '0;
    end else if (srstIn) begin
      {cStart, cStop, cRead, cWrite, cAck, cIack} <= '0;
    end else if (cmdAccept) begin
      cStart <= busWrData[CMD_STA];
      cStop  <= busWrData[CMD_STO];
      cRead  <= busWrData[CMD_RD];
      cWrite <= busWrData[CMD_WR];
      cAck   <= busWrData[CMD_ACK];
      cIack  <= busWrData[CMD_IACK];
    end else begin
      cIack <= 1'b0;
      if (cmdEnd) {cStart, cStop, cRead, cWrite, cAck} <= '0;
    end
  end

  // status, interrupt, received byte
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      stRxAck <= 1'b0; stBusy <= 1'b0; stArb <= 1'b0;
      irqFlag <= 1'b0; irqOut <= 1'b0; rxReg <= '0;
    end else if (srstIn) begin
      stRxAck <= 1'b0; stBusy <= 1'b0; stArb <= 1'b0;
      irqFlag <= 1'b0; irqOut <= 1'b0; rxReg <= '0;
    end else begin
      stRxAck <= ctlAckIn;
      stBusy  <= ctlBusy;
      if (ctlArbLost)  stArb <= 1'b1;
      else if (cStart) stArb <= 1'b0;
      irqFlag <= cmdEnd || (irqFlag && !cIack);
      irqOut  <= irqFlag && ctrlIen;
      if (ctlDone) rxReg <= ctlRxByte;
    end
  end

  // read path
  always_comb begin
    statusByte = '0;
    statusByte[7] = stRxAck;
    statusByte[6] = stBusy;
    statusByte[5] = stArb;
    statusByte[1] = tip;
    statusByte[0] = irqFlag;
    ctrlByte = '0;
    ctrlByte[CTL_EN]  = ctrlEn;
    ctrlByte[CTL_IEN] = ctrlIen;
    rdMux = '0;
    for (int b = 0; b < PRE_BYTES; b++)
      if (strb.addr == ADDR_W'(b)) rdMux = preReg[b*DATA_W +: DATA_W];
    if (strb.addr == ADR_CTRL) rdMux = ctrlByte;
    if (strb.addr == ADR_DATA) rdMux = rxReg;
    if (strb.addr == ADR_CMD)  rdMux = statusByte;
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)            busRdData <= '0;
    else if (srstIn)       busRdData <= '0;
    else if (strb.rdLatch) busRdData <= rdMux;
  end

  assign prescale  = preReg;
  assign coreEn    = ctrlEn;
  assign txByte    = txReg;
  assign cmdStart  = cStart;
  assign cmdStop   = cStop;
  assign cmdRead   = cRead;
  assign cmdWrite  = cWrite;
  assign cmdAckBit = cAck;

  // R5: a command write while disabled leaves the pending command alone
  assert_cmd_ignored_R5: assert property (@(posedge clk) disable iff (!arstN || srstIn)
    (strb.wrCmd && !ctrlEn && !cmdEnd) |=> $stable({cStart, cStop, cRead, cWrite, cAck}));

  // R6: completion clears transfer in progress unless a new command lands
  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!arstN || srstIn)
    (cmdEnd && !strb.wrCmd) |=> !(cmdRead || cmdWrite));

  // R6: interrupt acknowledge lasts one cycle
  assert_iack_pulse_R6: assert property (@(posedge clk) disable iff (!arstN || srstIn)
    cIack |=> !cIack);

  // R8: completion or arbitration loss raises the flag
  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!arstN || srstIn)
    cmdEnd |=> irqFlag);

  // R8: interrupt output only when enabled
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!arstN || srstIn)
    irqOut |-> $past(ctrlIen));

  // R9: arbitration loss is recorded
  assert_arb_sticky_R9: assert property (@(posedge clk) disable iff (!arstN || srstIn)
    (stArb && !cStart) |=> stArb);

endmodule

// File: rtl/i2cm_hostregs.sv
module i2cm_hostregs
  import i2cm_hostregs_pkg::*;
#(
  parameter logic ARST_LVL = 1'b0
) (
  input  logic              clk,
  input  logic              arstIn,
  input  logic              srstIn,
  input  logic              busCyc,
  input  logic              busStb,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busAck,
  output logic              irqOut,
  output logic [PRE_W-1:0]  prescale,
  output logic              coreEn,
  output logic [DATA_W-1:0] txByte,
  output logic              cmdStart,
  output logic              cmdStop,
  output logic              cmdRead,
  output logic              cmdWrite,
  output logic              cmdAckBit,
  input  logic              ctlDone,
  input  logic              ctlAckIn,
  input  logic              ctlBusy,
  input  logic              ctlArbLost,
  input  logic [DATA_W-1:0] ctlRxByte
);

  logic       arstN;
  regStrobe_t strb;

  // low whenever the asynchronous reset sits at its active level
  assign arstN = arstIn ^ ARST_LVL;

  i2cm_hostregs_ctl u_ctl (
    .clk     (clk),
    .arstN   (arstN),
    .srstIn  (srstIn),
    .busCyc  (busCyc),
    .busStb  (busStb),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busAck  (busAck),
    .strb    (strb)
  );

  i2cm_hostregs_dp u_dp (
    .clk        (clk),
    .arstN      (arstN),
    .srstIn     (srstIn),
    .strb       (strb),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .irqOut     (irqOut),
    .prescale   (prescale),
    .coreEn     (coreEn),
    .txByte     (txByte),
    .cmdStart   (cmdStart),
    .cmdStop    (cmdStop),
    .cmdRead    (cmdRead),
    .cmdWrite   (cmdWrite),
    .cmdAckBit  (cmdAckBit),
    .ctlDone    (ctlDone),
    .ctlAckIn   (ctlAckIn),
    .ctlBusy    (ctlBusy),
    .ctlArbLost (ctlArbLost),
    .ctlRxByte  (ctlRxByte)
  );

endmodule

// File: tb/i2cm_hostregs_bench.sv
module i2cm_hostregs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int STUB_LAT   = 8;

  logic       clk = 1'b0;
  logic       arstIn = 1'b0;
  logic       srstIn = 1'b0;
  logic       busCyc = 1'b0, busStb = 1'b0, busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       busAck, irqOut, coreEn;
  logic [15:0] prescale;
  logic [7:0] txByte;
  logic       cmdStart, cmdStop, cmdRead, cmdWrite, cmdAckBit;
  logic       ctlDone = 1'b0, ctlAckIn = 1'b0, ctlBusy = 1'b0, ctlArbLost = 1'b0;
  logic [7:0] ctlRxByte = '0;
  logic [7:0] stubRx = 8'h00;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  string      reqQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cm_hostregs u_i2cm_hostregs (
    .clk(clk), .arstIn(arstIn), .srstIn(srstIn),
    .busCyc(busCyc), .busStb(busStb), .busWe(busWe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .busAck(busAck),
    .irqOut(irqOut), .prescale(prescale), .coreEn(coreEn), .txByte(txByte),
    .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdRead(cmdRead),
    .cmdWrite(cmdWrite), .cmdAckBit(cmdAckBit),
    .ctlDone(ctlDone), .ctlAckIn(ctlAckIn), .ctlBusy(ctlBusy),
    .ctlArbLost(ctlArbLost), .ctlRxByte(ctlRxByte)
  );

  // sequencer stand-in: completes a read/write command after STUB_LAT cycles
  int stubSt = 0, stubCnt = 0;
  always @(posedge clk) begin
    case (stubSt)
      0: if (cmdRead || cmdWrite) begin stubCnt <= STUB_LAT; stubSt <= 1; end
      1: if (ctlArbLost) stubSt <= 3;
         else if (stubCnt == 0) begin ctlDone <= 1'b1; ctlRxByte <= stubRx; stubSt <= 2; end
         else stubCnt <= stubCnt - 1;
      2: begin ctlDone <= 1'b0; stubSt <= 3; end
      default: if (!(cmdRead || cmdWrite)) stubSt <= 0;
    endcase
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data with the acknowledge
  always @(posedge clk) begin
    #1;
    if (busAck && busStb && !busWe) begin
      if (expQ.size() == 0) check("R4 unexpected read ack", 16'h1, 16'h0);
      else check(reqQ.pop_front(), {8'h0, busRdData}, {8'h0, expQ.pop_front()});
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busCyc = 1; busStb = 1; busWe = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    check("R4 write ack", {15'h0, busAck}, 16'h1);
    busCyc = 0; busStb = 0; busWe = 0;
  endtask

  task automatic busRead(input logic [2:0] a, input logic [7:0] exp, input string req);
    expQ.push_back(exp); reqQ.push_back(req);
    @(negedge clk);
    busCyc = 1; busStb = 1; busWe = 0; busAddr = a;
    @(negedge clk);
    check("R4 read ack", {15'h0, busAck}, 16'h1);
    busCyc = 0; busStb = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: got 0x1 expected 0x0");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    idle(3);
    arstIn = 1'b1;
    idle(2);
    // R2 reset state
    check("R2 prescale port", prescale, 16'hFFFF);
    check("R2 cmd outputs", {11'h0, cmdStart, cmdStop, cmdRead, cmdWrite, cmdAckBit}, 16'h0);
    check("R2 irqOut", {15'h0, irqOut}, 16'h0);
    check("R4 ack idle", {15'h0, busAck}, 16'h0);
    busRead(3'd0, 8'hFF, "R2 prescale lo");
    busRead(3'd1, 8'hFF, "R2 prescale hi");
    busRead(3'd2, 8'h00, "R2 ctrl");
    busRead(3'd3, 8'h00, "R2 rx");
    busRead(3'd4, 8'h00, "R2 status");

    // R1 divider and control
    busWrite(3'd0, 8'h3F);
    busWrite(3'd1, 8'h00);
    busRead(3'd0, 8'h3F, "R1 prescale lo");
    busRead(3'd1, 8'h00, "R1 prescale hi");
    check("R1 prescale port", prescale, 16'h003F);
    busWrite(3'd2, 8'hFF);
    busRead(3'd2, 8'hC0, "R1 ctrl only bits 7,6");
    check("R1 coreEn", {15'h0, coreEn}, 16'h1);

    // R5 commands ignored while disabled; R3 byte to send
    busWrite(3'd2, 8'h00);
    busWrite(3'd3, 8'hA2);
    check("R3 txByte", {8'h0, txByte}, 16'h00A2);
    busWrite(3'd4, 8'h90);
    idle(2);
    check("R5 disabled cmd", {14'h0, cmdStart, cmdWrite}, 16'h0);
    busRead(3'd4, 8'h00, "R5 status after ignored cmd");

    // start+write, interrupts off
    busWrite(3'd2, 8'h80);
    ctlBusy = 1'b1; ctlAckIn = 1'b0;
    busWrite(3'd4, 8'h90);
    check("R3 cmd start/write", {14'h0, cmdStart, cmdWrite}, 16'h3);
    busRead(3'd4, 8'h42, "R7 status busy+tip");
    idle(14);
    busRead(3'd4, 8'h41, "R7 status after done");
    check("R6 cmd cleared", {11'h0, cmdStart, cmdStop, cmdRead, cmdWrite, cmdAckBit}, 16'h0);
    check("R8 irq masked", {15'h0, irqOut}, 16'h0);

    // R8 enable interrupt, then acknowledge
    busWrite(3'd2, 8'hC0);
    idle(2);
    check("R8 irq enabled", {15'h0, irqOut}, 16'h1);
    busWrite(3'd4, 8'h01);
    idle(3);
    check("R8 irq after iack", {15'h0, irqOut}, 16'h0);
    busRead(3'd4, 8'h40, "R8 status after iack");

    // R10 read with nack and stop
    stubRx = 8'h5A; ctlAckIn = 1'b1; ctlBusy = 1'b0;
    busWrite(3'd4, 8'h68);
    check("R6 read/stop/ack outputs", {13'h0, cmdStop, cmdRead, cmdAckBit}, 16'h7);
    idle(14);
    busRead(3'd3, 8'h5A, "R10 rx byte");
    busRead(3'd4, 8'h81, "R10 status rxack");
    check("R6 ack bit cleared", {15'h0, cmdAckBit}, 16'h0);
    busWrite(3'd4, 8'h01);

    // R9 arbitration loss
    ctlAckIn = 1'b0;
    busWrite(3'd4, 8'h10);
    idle(2);
    ctlArbLost = 1'b1;
    idle(1);
    ctlArbLost = 1'b0;
    idle(3);
    check("R6 arb clears cmd", {15'h0, cmdWrite}, 16'h0);
    check("R8 irq on arb", {15'h0, irqOut}, 16'h1);
    busRead(3'd4, 8'h21, "R9 status arb");
    busWrite(3'd4, 8'h01);
    busRead(3'd4, 8'h20, "R9 arb sticky");
    busWrite(3'd4, 8'h90);
    idle(1);
    busRead(3'd4, 8'h02, "R9 start clears arb");
    idle(14);
    busRead(3'd4, 8'h01, "R7 done again");
    busWrite(3'd4, 8'h01);

    // R5 pending command survives disable; iack ignored while disabled
    busWrite(3'd4, 8'h10);
    busWrite(3'd2, 8'h00);
    check("R5 pending cmd held", {15'h0, cmdWrite}, 16'h1);
    idle(14);
    check("R5 pending completes", {15'h0, cmdWrite}, 16'h0);
    busWrite(3'd4, 8'h01);
    busRead(3'd4, 8'h01, "R5 iack ignored when disabled");

    // R11 synchronous reset
    busWrite(3'd0, 8'h12);
    @(negedge clk); srstIn = 1'b1;
    @(negedge clk); srstIn = 1'b0;
    busRead(3'd0, 8'hFF, "R11 sync reset prescale");
    busRead(3'd4, 8'h00, "R11 sync reset status");

    // R11 asynchronous reset, active low
    busWrite(3'd2, 8'hC0);
    @(negedge clk); #2 arstIn = 1'b0; #2 arstIn = 1'b1;
    check("R11 async reset coreEn", {15'h0, coreEn}, 16'h0);
    busRead(3'd2, 8'h00, "R11 async reset ctrl");

    idle(3);
    if (expQ.size() != 0) check("R4 outstanding reads", 16'(expQ.size()), 16'h0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule